// File: doc/BRIEF.md
# Execution Region Monitor

This block watches the instruction-fetch side of a CPU memory port and raises a sticky flag when the CPU tries to execute from an address range that software has marked as non-executable. Typical ranges are a stack or a data buffer. Software programs the range bounds and then arms the monitor. Arming is one-way: once the monitor is armed, it cannot be disarmed, and the range bounds cannot be changed. A program that sets up the protection therefore cannot later remove it.

The block has one write port for its three write-only configuration words: control, lower bound and upper bound. It also observes a memory-access triple of valid, instruction flag and address. When an armed monitor sees an instruction fetch that falls inside the bounds, it sets `violation_o` one clock later. That flag stays high until reset. A surrounding system can use it to stop the CPU.

Top module: `exec_region_monitor`

## Requirements
- R1: After reset, `violation_o` is 0, the monitor is disarmed, and both bounds are 0.
- R2: A write with `cfg_sel_i` = 0 selects the control word, and bit 0 of `cfg_wdata_i` arms the monitor. A control write whose bit 0 is 0 does not arm it, even when other bits are set. Select 1 writes the lower bound, select 2 writes the upper bound, and select 3 writes nothing.
- R3: Once armed, the monitor stays armed. A later control write with bit 0 cleared has no effect.
- R4: While armed, writes to the lower or upper bound are ignored, and the range in force stays the one programmed before arming.
- R5: The range is inclusive at both ends. A fetch at the lower bound or at the upper bound is a hit. Addresses one below the lower bound or one above the upper bound are not hits.
- R6: Once `violation_o` is set, it stays 1 until `rst_ni` is asserted.
- R7: If the lower bound is greater than the upper bound, the region is empty, and no fetch ever sets `violation_o`.
- R8: Only accesses with `mem_instr_i` = 1 can trip the monitor. Data reads and writes inside the range have no effect.
- R9: While disarmed, no access sets `violation_o`. Arming takes effect in the cycle after the control write, so a fetch in the same cycle as that write does not trip the monitor.
- R10: `violation_o` rises in the cycle after the clock edge that samples the offending fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Word select: 0 control, 1 lower bound, 2 upper bound |
| cfg_wdata_i | input | DATA_W | Write data |
| mem_valid_i | input | 1 | Memory access valid |
| mem_instr_i | input | 1 | Access is an instruction fetch |
| mem_addr_i | input | ADDR_W | Access address |
| violation_o | output | 1 | Sticky execution-violation flag |

## Verification
The configuration words are write-only, so the bench can never read back whether the monitor is armed or whether a bound write was dropped. Both facts have to be shown through `violation_o`, and because the flag is sticky, each such fact needs a fresh reset. The stimulus first arms the monitor, then tries to move the bounds or clear the arm bit. It then fetches at an address that is a hit only under the original configuration, and checks the flag. A separate run fetches in the exact cycle of the arming write to pin down when arming takes effect.

// File: rtl/exec_mon_pkg.sv
package exec_mon_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_FIRST = 2'd1,
    SEL_LAST  = 2'd2,
    SEL_RSVD  = 2'd3
  } cfg_sel_e;

  localparam int unsigned CTRL_ARM_BIT = 0;
endpackage

// File: rtl/exec_mon_cfg.sv
module exec_mon_cfg
  import exec_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              armed_o,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] last_o
);
  cfg_sel_e sel;
  logic     arm_set, first_we, last_we;

  assign sel      = cfg_sel_e'(sel_i);
  assign arm_set  = we_i && (sel == SEL_CTRL) && wdata_i[CTRL_ARM_BIT];
  // bounds freeze once armed
  assign first_we = we_i && !armed_o && (sel == SEL_FIRST);
  assign last_we  = we_i && !armed_o && (sel == SEL_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
    end else if (arm_set) begin
      armed_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_o <= '0;
    end else if (first_we) begin
      first_o <= wdata_i[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_o <= '0;
    end else if (last_we) begin
      last_o <= wdata_i[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/exec_mon_cmp.sv
module exec_mon_cmp #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              armed_i,
  input  logic              valid_i,
  input  logic              instr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic              hit_o
);
  logic [1:0] bound_ok;

  // index 0: lower bound, index 1: upper bound
  for (genvar g = 0; g < 2; g++) begin : g_bound
    if (g == 0) begin : g_lo
      assign bound_ok[g] = (addr_i >= first_i);
    end else begin : g_hi
      assign bound_ok[g] = (addr_i <= last_i);
    end
  end

  assign hit_o = armed_i && valid_i && instr_i && (&bound_ok);
endmodule

// File: rtl/exec_mon_trip.sv
module exec_mon_trip (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic trip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_o <= 1'b0;
    end else if (hit_i) begin
      trip_o <= 1'b1;
    end
  end
endmodule

// File: rtl/exec_region_monitor.sv
module exec_region_monitor #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              mem_valid_i,
  input  logic              mem_instr_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  output logic              violation_o
);
  logic              armed_q;
  logic [ADDR_W-1:0] first_q, last_q;
  logic              hit;

  exec_mon_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .armed_o (armed_q),
    .first_o (first_q),
    .last_o  (last_q)
  );

  exec_mon_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .armed_i (armed_q),
    .valid_i (mem_valid_i),
    .instr_i (mem_instr_i),
    .addr_i  (mem_addr_i),
    .first_i (first_q),
    .last_i  (last_q),
    .hit_o   (hit)
  );

  exec_mon_trip u_trip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .trip_o (violation_o)
  );
endmodule

// File: rtl/exec_region_monitor_chk.sv
module exec_region_monitor_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              armed_i,
  input logic [ADDR_W-1:0] first_i,
  input logic [ADDR_W-1:0] last_i,
  input logic              mem_valid_i,
  input logic              mem_instr_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              violation_i
);
  p_arm_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |=> armed_i);

  p_bounds_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |=> ($stable(first_i) && $stable(last_i)));

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_i |=> violation_i);

  p_empty_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && (first_i > last_i) && !violation_i) |=> !violation_i);

  p_data_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!violation_i && !(mem_valid_i && mem_instr_i)) |=> !violation_i);

  p_disarmed_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> !violation_i);

  p_rise_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(violation_i) |-> $past(armed_i && mem_valid_i && mem_instr_i
                                 && (mem_addr_i >= first_i) && (mem_addr_i <= last_i)));
endmodule

bind exec_region_monitor exec_region_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .armed_i     (armed_q),
  .first_i     (first_q),
  .last_i      (last_q),
  .mem_valid_i (mem_valid_i),
  .mem_instr_i (mem_instr_i),
  .mem_addr_i  (mem_addr_i),
  .violation_i (violation_o)
);

// File: tb/sim_exec_region_monitor.sv
`timescale 1ns/1ps
module sim_exec_region_monitor;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;

  typedef struct {
    logic  exp;
    string tag;
  } exp_item_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_sel_i = '0;
  logic [DW-1:0] cfg_wdata_i = '0;
  logic          mem_valid_i = 1'b0;
  logic          mem_instr_i = 1'b0;
  logic [AW-1:0] mem_addr_i = '0;
  logic          violation_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;
  exp_item_t sb[$];

  always #4 clk_i = ~clk_i;

  exec_region_monitor #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i,
    .mem_valid_i, .mem_instr_i, .mem_addr_i, .violation_o
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: violation_o=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: compare output against queued expectation
  always @(negedge clk_i) begin
    if (sb.size() > 0) begin
      exp_item_t it;
      it = sb.pop_front();
      check(violation_o, it.exp, it.tag);
    end
  end

  task automatic step(input logic we, input logic [1:0] sel, input logic [DW-1:0] wd,
                      input logic mv, input logic mi, input logic [AW-1:0] ma,
                      input logic exp, input string tag);
    exp_item_t it;
    @(negedge clk_i);
    cfg_we_i = we; cfg_sel_i = sel; cfg_wdata_i = wd;
    mem_valid_i = mv; mem_instr_i = mi; mem_addr_i = ma;
    @(posedge clk_i);
    #1;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] wd, input logic exp, input string tag);
    step(1'b1, sel, wd, 1'b0, 1'b0, '0, exp, tag);
  endtask

  task automatic fetch(input logic [AW-1:0] a, input logic exp, input string tag);
    step(1'b0, 2'd0, '0, 1'b1, 1'b1, a, exp, tag);
  endtask

  task automatic idle(input logic exp, input string tag);
    step(1'b0, 2'd0, '0, 1'b0, 1'b0, '0, exp, tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    while (sb.size() > 0) @(negedge clk_i);
    cfg_we_i = 1'b0; mem_valid_i = 1'b0; mem_instr_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(violation_o, 1'b0, "R1 reset value");
  endtask

  initial begin : watchdog
    while (!done && cycles < 5000) begin
      @(posedge clk_i);
      cycles++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: cycles=%0d expected<5000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    // run A: arming, inclusive edges, data access, sticky arm and flag
    do_reset();
    fetch(32'h0, 1'b0, "R1/R9 default range while disarmed");
    wr(2'd1, 32'h100, 1'b0, "R2 write lower bound");
    wr(2'd2, 32'h1FF, 1'b0, "R2 write upper bound");
    fetch(32'h150, 1'b0, "R9 fetch in range while disarmed");
    wr(2'd0, 32'hFFFF_FFFE, 1'b0, "R2 control write without bit0");
    fetch(32'h150, 1'b0, "R2 bit0 clear does not arm");
    wr(2'd3, 32'hFFFF_FFFF, 1'b0, "R2 reserved select");
    step(1'b1, 2'd0, 32'h1, 1'b1, 1'b1, 32'h150, 1'b0, "R9 fetch in arming cycle");
    step(1'b0, 2'd0, '0, 1'b1, 1'b0, 32'h150, 1'b0, "R8 data access in range");
    fetch(32'hFF, 1'b0, "R5 one below lower bound");
    fetch(32'h200, 1'b0, "R5 one above upper bound");
    wr(2'd0, 32'h0, 1'b0, "R3 clear attempt");
    fetch(32'h100, 1'b1, "R3/R5/R10 hit at lower bound");
    for (int i = 0; i < 4; i++) idle(1'b1, "R6 flag holds");

    // run B: bounds locked after arming
    do_reset();
    wr(2'd1, 32'h100, 1'b0, "R4 setup lower");
    wr(2'd2, 32'h1FF, 1'b0, "R4 setup upper");
    wr(2'd0, 32'h1, 1'b0, "R4 arm");
    wr(2'd1, 32'h300, 1'b0, "R4 move lower");
    wr(2'd2, 32'h3FF, 1'b0, "R4 move upper");
    fetch(32'h350, 1'b0, "R4 fetch in ignored range");
    fetch(32'h1FF, 1'b1, "R4/R5 hit at upper bound");
    idle(1'b1, "R6 flag holds after upper hit");

    // run C: inverted bounds give empty region
    do_reset();
    wr(2'd1, 32'h500, 1'b0, "R7 lower above upper");
    wr(2'd2, 32'h400, 1'b0, "R7 upper");
    wr(2'd0, 32'h1, 1'b0, "R7 arm");
    fetch(32'h450, 1'b0, "R7 fetch between");
    fetch(32'h400, 1'b0, "R7 fetch at upper");
    fetch(32'h500, 1'b0, "R7 fetch at lower");

    // run D: reset clears the flag
    wr(2'd0, 32'h1, 1'b0, "R6 re-arm (no effect)");
    do_reset();
    fetch(32'h0, 1'b0, "R1 disarmed after reset");

    idle(1'b0, "R9 idle");
    @(negedge clk_i);
    while (sb.size() > 0) @(negedge clk_i);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule